// File: doc/BRIEF.md
# Rail Supervisor Clear-on-Read Status Bank

This block holds the error status that a voltage-rail supervisor exposes on its byte-wide register bus. It records two kinds of event. The first is a failed bus access, stored with a two-bit code that gives the cause. The second is an alarm from any rail monitor, stored as one bit per rail and also as one summary bit. Event strobes come in from the bus front end and from the rail monitors. The block presents the current value of three 8-bit registers: one status byte and two rail-mask bytes.

Reads clear the registers. A read of the status byte clears every bit except a reserved sticky flag, which stays set until reset. A read of a rail byte clears only that byte. A 16-bit word read asserts both rail read strobes together. When an event arrives in the same cycle as a clearing read, the event wins, so no fault is lost. Each clear takes effect on the clock edge that ends the read cycle. The data returned during the read cycle is the value held before the clear.

Top module: `rail_fault_status`

## Requirements
- R1: After reset, all three output bytes read as zero.
- R2: A bus-fault strobe sets status bit 7 on the next clock edge and loads status bits 1:0 with the cause code. The codes are 01 for an invalid address, 10 for a read fault and 11 for a write fault. Bits 1:0 are 00 while bit 7 is clear.
- R3: A second bus fault that arrives before the status byte is read replaces the cause code with the newest cause.
- R4: An alarm strobe on rail n sets bit n of the 16-bit rail mask, which is {high byte, low byte}. It also sets status bit 6.
- R5: A status read clears bits 7, 6 and 1:0 on the next edge. Status bits 4:2 always read zero.
- R6: The sticky flag, status bit 5, is set by its own strobe. A status read does not clear it; only reset does.
- R7: A low-byte read clears only mask bits 7:0, and a high-byte read clears only mask bits 15:8. Asserting both strobes together reads and clears the whole 16-bit word.
- R8: When an event arrives in the same cycle as a read that would clear its bit, the bit stays set.
- R9: A status read leaves the rail mask unchanged, and a rail read leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_fault_i | input | 1 | Strobe: a register access failed |
| bus_cause_i | input | 2 | Cause code for the bus fault |
| rsvd_flag_set_i | input | 1 | Strobe that sets the sticky reserved flag |
| rail_alarm_i | input | N_RAILS | Per-rail alarm strobes |
| rd_status_i | input | 1 | Read of the status byte (clears it) |
| rd_rail_lo_i | input | 1 | Read of rail mask bits 7:0 (clears them) |
| rd_rail_hi_i | input | 1 | Read of rail mask bits 15:8 (clears them) |
| status_o | output | 8 | Status byte |
| rail_lo_o | output | 8 | Rail mask bits 7:0 |
| rail_hi_o | output | 8 | Rail mask bits 15:8 |

## Verification
The bench builds the block with the default of N_RAILS = 16. With that value the rails in both mask bytes can be driven, including bit 15. Both bytes can then be cleared alone and as a word, while alarms in the same cycle keep bits set in both halves. The collisions checked are:
- a bus fault during a status read;
- alarms on bits 0 and 8 during a high-byte read;
- a sticky flag that survives status reads and is cleared only by a second reset.

// File: rtl/rail_fault_status.sv
module rail_fault_status #(
  parameter int N_RAILS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_fault_i,
  input  logic [1:0]         bus_cause_i,
  input  logic               rsvd_flag_set_i,
  input  logic [N_RAILS-1:0] rail_alarm_i,
  input  logic               rd_status_i,
  input  logic               rd_rail_lo_i,
  input  logic               rd_rail_hi_i,
  output logic [7:0]         status_o,
  output logic [7:0]         rail_lo_o,
  output logic [7:0]         rail_hi_o
);
  localparam int MASK_W = 16;

  logic [MASK_W-1:0] alarm_w;
  logic [MASK_W-1:0] mask_q;
  logic [MASK_W-1:0] clr_w;
  logic              fault_q;
  logic [1:0]        cause_q;
  logic              any_q;
  logic              sticky_q;
  logic              any_alarm;

  generate
    if (N_RAILS < MASK_W) begin : g_pad
      assign alarm_w = {{(MASK_W-N_RAILS){1'b0}}, rail_alarm_i};
    end else begin : g_full
      assign alarm_w = rail_alarm_i[MASK_W-1:0];
    end
  endgenerate

  assign any_alarm = |rail_alarm_i;
  assign clr_w     = {{8{rd_rail_hi_i}}, {8{rd_rail_lo_i}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= 1'b0;
      cause_q  <= 2'b00;
      any_q    <= 1'b0;
      sticky_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (bus_fault_i) begin
        fault_q <= 1'b1;
        cause_q <= bus_cause_i;
      end else if (rd_status_i) begin
        fault_q <= 1'b0;
        cause_q <= 2'b00;
      end
      if (any_alarm)        any_q <= 1'b1;
      else if (rd_status_i) any_q <= 1'b0;
      if (rsvd_flag_set_i) sticky_q <= 1'b1;
      mask_q <= alarm_w | (mask_q & ~clr_w);
    end
  end

  assign status_o  = {fault_q, any_q, sticky_q, 3'b000, cause_q};
  assign rail_lo_o = mask_q[7:0];
  assign rail_hi_o = mask_q[15:8];
endmodule

module rail_fault_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_fault_i,
  input logic [1:0]  bus_cause_i,
  input logic        any_alarm,
  input logic [15:0] alarm_w,
  input logic        rd_status_i,
  input logic        rd_rail_lo_i,
  input logic        rd_rail_hi_i,
  input logic [7:0]  status_o,
  input logic [7:0]  rail_lo_o,
  input logic [7:0]  rail_hi_o
);
  assert_fault_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault_i |=> status_o[7] && status_o[1:0] == $past(bus_cause_i));

  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status_i && !bus_fault_i && !any_alarm |=> status_o[7:6] == 2'b00 && status_o[1:0] == 2'b00);

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5] |=> status_o[5]);

  assert_alarm_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_alarm |=> status_o[6]);

  assert_lo_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rail_lo_i && alarm_w[7:0] == 8'h00 |=> rail_lo_o == 8'h00);

  assert_hi_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rail_hi_i |=> (rail_hi_o & $past(rail_hi_o)) == $past(rail_hi_o));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rail_lo_i && alarm_w[0] |=> rail_lo_o[0]);

  assert_mask_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rail_lo_i && !rd_rail_hi_i |=> ({rail_hi_o, rail_lo_o} & $past({rail_hi_o, rail_lo_o})) == $past({rail_hi_o, rail_lo_o}));
endmodule

bind rail_fault_status rail_fault_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_fault_i(bus_fault_i), .bus_cause_i(bus_cause_i),
  .any_alarm(any_alarm), .alarm_w(alarm_w), .rd_status_i(rd_status_i),
  .rd_rail_lo_i(rd_rail_lo_i), .rd_rail_hi_i(rd_rail_hi_i),
  .status_o(status_o), .rail_lo_o(rail_lo_o), .rail_hi_o(rail_hi_o)
);

// File: tb/rail_fault_status_tb.sv
module rail_fault_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAILS    = 16;

  typedef struct packed {
    logic        fault;
    logic [1:0]  cause;
    logic        rsvd;
    logic        rds;
    logic        rdl;
    logic        rdh;
    logic [15:0] alarm;
    logic [7:0]  exp_st;
    logic [15:0] exp_rail;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h81, 16'h0000},
    '{1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h83, 16'h0000},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0004, 8'hC3, 16'h0004},
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, 16'h0004},
    '{1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8000, 8'h60, 16'h8004},
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h20, 16'h8004},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h20, 16'h8000},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0101, 8'h60, 16'h0101},
    '{1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'hA2, 16'h0101},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 8'hA2, 16'h0000},
    '{1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h20, 16'h0000}
  };
  localparam string TAG [NV] = '{"R2", "R3", "R4", "R5 R9", "R4 R6", "R6", "R7 R9",
                                 "R7 R8", "R8", "R7", "R5 R6"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_fault_i = 1'b0;
  logic [1:0] bus_cause_i = 2'b00;
  logic rsvd_flag_set_i = 1'b0;
  logic [N_RAILS-1:0] rail_alarm_i = '0;
  logic rd_status_i = 1'b0, rd_rail_lo_i = 1'b0, rd_rail_hi_i = 1'b0;
  logic [7:0] status_o, rail_lo_o, rail_hi_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_fault_status #(.N_RAILS(N_RAILS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_fault_i(bus_fault_i), .bus_cause_i(bus_cause_i),
    .rsvd_flag_set_i(rsvd_flag_set_i), .rail_alarm_i(rail_alarm_i),
    .rd_status_i(rd_status_i), .rd_rail_lo_i(rd_rail_lo_i), .rd_rail_hi_i(rd_rail_hi_i),
    .status_o(status_o), .rail_lo_o(rail_lo_o), .rail_hi_o(rail_hi_o)
  );

  task automatic check(input string req, input logic [7:0] st, input logic [15:0] rail);
    checks++;
    if (status_o !== st || {rail_hi_o, rail_lo_o} !== rail) begin
      errors++;
      $display("FAIL %s: status=%h rail=%h expected status=%h rail=%h",
               req, status_o, {rail_hi_o, rail_lo_o}, st, rail);
    end
  endtask

  task automatic idle();
    bus_fault_i = 1'b0; bus_cause_i = 2'b00; rsvd_flag_set_i = 1'b0;
    rail_alarm_i = '0; rd_status_i = 1'b0; rd_rail_lo_i = 1'b0; rd_rail_hi_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R1", 8'h00, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 8'h00, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_fault_i = VEC[i].fault; bus_cause_i = VEC[i].cause;
      rsvd_flag_set_i = VEC[i].rsvd; rail_alarm_i = VEC[i].alarm;
      rd_status_i = VEC[i].rds; rd_rail_lo_i = VEC[i].rdl; rd_rail_hi_i = VEC[i].rdh;
      @(posedge clk); #1;
      check(TAG[i], VEC[i].exp_st, VEC[i].exp_rail);
    end

    @(negedge clk); idle();
    @(posedge clk); #1;
    check("R6 idle hold", 8'h20, 16'h0000);

    @(negedge clk); rail_alarm_i = 16'hFFFF;
    @(posedge clk); #1;
    check("R4 all rails", 8'h60, 16'hFFFF);
    @(negedge clk); idle(); rd_rail_hi_i = 1'b1;
    @(posedge clk); #1;
    check("R7 hi only", 8'h60, 16'h00FF);

    @(negedge clk); idle(); rst_n = 1'b0;
    #1;
    check("R1 R6 reset clears sticky", 8'h00, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 8'h00, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule